// File: doc/BRIEF.md
# Rotating Word Shifter with Per-Pin Double-Rate Output Mapping

This block is the serial output stage of a fast transmit path. Thirty-two-bit words enter through a small write queue. While the block is enabled, a step strobe fires once every divider period. Each step either rotates the held word toward the least significant bit by a programmed amount, or it loads the next queued word once the programmed number of rotations has been done. Eight output pins are built from the held word. Each pin gives two values per system cycle, one for the first half of the output clock period and one for the second half, so a double-rate pad stage can serialise them.

Each pin is set independently. In data mode it shows two register bits that it selects itself, one per half period. In clock mode it shows a generated clock. That clock is `clkDiv` system cycles long, and its start is offset by `clkPhase` half-cycle slots. Either mode can be inverted. A phase value that does not fit inside the period is treated as zero, and the block raises an error flag while that setting is applied. The queue reports full and empty. A sticky flag records any write that arrived while the queue was full.

Top module: `ddr_word_shifter`

## Requirements
- R1: While `enable` is low no word leaves the queue, the held word does not change and the divider counter sits at zero. Writes are still accepted until the queue is full.
- R2: While enabled, a step occurs on the last cycle of every period of D system cycles, where D is `clkDiv` and a value of 0 acts as 1. A step that does not load rotates the held word right (toward bit 0) by `shiftAmt` and lowers the remaining-rotation count by one, but not below zero.
- R3: A step that finds the remaining count at zero and the queue not empty loads the oldest queued word and sets the remaining count to `shiftCount`. The remaining count is zero after reset, so the first step loads.
- R4: A step that finds the remaining count at zero and the queue empty rotates the held word. The next step at which a word is present loads it.
- R5: A pin in data mode (`pinClkMode[p]`=0) drives `pinFirst[p]` from held-word bit `pinSelFirst[5p+4:5p]` and `pinSecond[p]` from bit `pinSelSecond[5p+4:5p]`. Each value is XOR-ed with `pinInvert[p]`.
- R6: A pin in clock mode drives a clock built from half-cycle slots. Slot k (2×divider count for the first half, plus one for the second half) is high when (k − P + 2D) mod 2D < D, where P is the effective phase. The result is XOR-ed with `pinInvert[p]`.
- R7: When `clkPhase` ≥ 2D, `phaseErr` is high and the effective phase is 0. Otherwise `phaseErr` is low and P equals `clkPhase`.
- R8: The queue holds `FIFO_DEPTH` words in order and flags `fifoFull` and `fifoEmpty`. A write while full (counted before any same-cycle removal) is dropped and the stored words are unchanged.
- R9: `fifoWof` is set by a write while full and stays set until a cycle with `wofClear` high and no new overflow. A new overflow in the same cycle as a clear leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Runs the divider and shifter |
| wrValid | input | 1 | Queue write strobe |
| wrData | input | 32 | Word to queue |
| wofClear | input | 1 | Clears the overflow flag |
| shiftAmt | input | 5 | Rotation per step |
| shiftCount | input | 5 | Rotations before the next load |
| clkDiv | input | 4 | System cycles per output clock period (0 acts as 1) |
| clkPhase | input | 5 | Clock offset in half-cycle slots |
| pinClkMode | input | 8 | Per pin: 1 clock, 0 data |
| pinInvert | input | 8 | Per pin output inversion |
| pinSelFirst | input | 40 | Per pin first-half bit select, 5 bits each |
| pinSelSecond | input | 40 | Per pin second-half bit select, 5 bits each |
| pinFirst | output | 8 | First-half value of each pin |
| pinSecond | output | 8 | Second-half value of each pin |
| fifoFull | output | 1 | Queue full |
| fifoEmpty | output | 1 | Queue empty |
| fifoWof | output | 1 | Sticky write-while-full flag |
| phaseErr | output | 1 | Phase setting out of range |

## Verification
Some properties are checked on every cycle. The full and empty flags are never high together. A full queue stays full unless a load removes a word. The overflow flag sets, holds and clears as R9 says. No load happens while the block is disabled or the queue is empty. Other behaviour only shows up in the bench's scenarios, where a behavioural queue-and-integer model is compared on every clock. This covers the order in which words are loaded, the rotation amounts, the reload count, the half-slot clock shape for several divider and phase values including an illegal phase, and the bit selection and inversion on each pin.

// File: rtl/wsh_pkg.sv
package wsh_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = $clog2(WORD_W);

  typedef struct packed {
    logic load;
    logic rotate;
    logic clkFirst;
    logic clkSecond;
  } ctl_strobe_t;
endpackage

// File: rtl/wsh_fifo.sv
module wsh_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrValid,
  input  logic [W-1:0] wrData,
  input  logic         pop,
  input  logic         wofClear,
  output logic [W-1:0] rdData,
  output logic         full,
  output logic         empty,
  output logic         wof
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          wrAccept, popOk;

  assign full     = (count == CW'(DEPTH));
  assign empty    = (count == '0);
  assign wrAccept = wrValid && !full;
  assign popOk    = pop && !empty;
  assign rdData   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (wrAccept) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
      wof   <= 1'b0;
    end else begin
      if (wrAccept) wrPtr <= AW'(wrPtr + 1'b1);
      if (popOk)    rdPtr <= AW'(rdPtr + 1'b1);
      count <= count + CW'(wrAccept) - CW'(popOk);
      if (wrValid && full) wof <= 1'b1;
      else if (wofClear)   wof <= 1'b0;
    end
  end
endmodule

// File: rtl/wsh_ctrl.sv
module wsh_ctrl import wsh_pkg::*; #(
  parameter int DIV_W = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [DIV_W:0]   clkPhase,
  input  logic [CNT_W-1:0] shiftCount,
  input  logic             fifoEmpty,
  output ctl_strobe_t      strobes,
  output logic             phaseErr
);
  localparam int SLOT_W = DIV_W + 2;

  logic [DIV_W-1:0]  divEff, divCnt;
  logic [SLOT_W-1:0] slots, phaseEff, kFirst, kSecond;
  logic [CNT_W-1:0]  stepsLeft;
  logic              tick;

  function automatic logic clkLevel(input logic [SLOT_W-1:0] k,
                                    input logic [SLOT_W-1:0] period,
                                    input logic [SLOT_W-1:0] ph,
                                    input logic [DIV_W-1:0]  half);
    logic [SLOT_W:0] t;
    t = {1'b0, k} + {1'b0, period} - {1'b0, ph};
    if (t >= {1'b0, period}) t = t - {1'b0, period};
    return t < {3'b000, half};
  endfunction

  assign divEff   = (clkDiv == '0) ? DIV_W'(1) : clkDiv;
  assign slots    = {1'b0, divEff, 1'b0};
  assign phaseErr = ({1'b0, clkPhase} >= slots);
  assign phaseEff = phaseErr ? '0 : {1'b0, clkPhase};
  assign tick     = enable && (divCnt >= divEff - DIV_W'(1));
  assign kFirst   = {1'b0, divCnt, 1'b0};
  assign kSecond  = {1'b0, divCnt, 1'b1};

  always_comb begin
    strobes.load      = tick && (stepsLeft == '0) && !fifoEmpty;
    strobes.rotate    = tick && !strobes.load;
    strobes.clkFirst  = clkLevel(kFirst,  slots, phaseEff, divEff);
    strobes.clkSecond = clkLevel(kSecond, slots, phaseEff, divEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      stepsLeft <= '0;
    end else begin
      if (!enable || tick) divCnt <= '0;
      else                 divCnt <= DIV_W'(divCnt + 1'b1);
      if (strobes.load)
        stepsLeft <= shiftCount;
      else if (strobes.rotate && stepsLeft != '0)
        stepsLeft <= CNT_W'(stepsLeft - 1'b1);
    end
  end
endmodule

// File: rtl/wsh_datapath.sv
module wsh_datapath import wsh_pkg::*; #(
  parameter int PINS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctl_strobe_t           strobes,
  input  logic [WORD_W-1:0]     loadWord,
  input  logic [SEL_W-1:0]      shiftAmt,
  input  logic [PINS-1:0]       pinClkMode,
  input  logic [PINS-1:0]       pinInvert,
  input  logic [PINS*SEL_W-1:0] pinSelFirst,
  input  logic [PINS*SEL_W-1:0] pinSelSecond,
  output logic [PINS-1:0]       pinFirst,
  output logic [PINS-1:0]       pinSecond
);
  logic [WORD_W-1:0]   shiftReg, rotated;
  logic [2*WORD_W-1:0] doubled;

  assign doubled = {shiftReg, shiftReg} >> shiftAmt;
  assign rotated = doubled[WORD_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               shiftReg <= '0;
    else if (strobes.load)   shiftReg <= loadWord;
    else if (strobes.rotate) shiftReg <= rotated;
  end

  for (genvar g = 0; g < PINS; g++) begin : gPin
    logic [SEL_W-1:0] selA, selB;
    logic             srcA, srcB;
    assign selA = pinSelFirst[g*SEL_W +: SEL_W];
    assign selB = pinSelSecond[g*SEL_W +: SEL_W];
    assign srcA = pinClkMode[g] ? strobes.clkFirst  : shiftReg[selA];
    assign srcB = pinClkMode[g] ? strobes.clkSecond : shiftReg[selB];
    assign pinFirst[g]  = srcA ^ pinInvert[g];
    assign pinSecond[g] = srcB ^ pinInvert[g];
  end
endmodule

// File: rtl/ddr_word_shifter.sv
module ddr_word_shifter import wsh_pkg::*; #(
  parameter int FIFO_DEPTH = 4,
  parameter int PINS       = 8,
  parameter int DIV_W      = 4,
  parameter int CNT_W      = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enable,
  input  logic                  wrValid,
  input  logic [WORD_W-1:0]     wrData,
  input  logic                  wofClear,
  input  logic [SEL_W-1:0]      shiftAmt,
  input  logic [CNT_W-1:0]      shiftCount,
  input  logic [DIV_W-1:0]      clkDiv,
  input  logic [DIV_W:0]        clkPhase,
  input  logic [PINS-1:0]       pinClkMode,
  input  logic [PINS-1:0]       pinInvert,
  input  logic [PINS*SEL_W-1:0] pinSelFirst,
  input  logic [PINS*SEL_W-1:0] pinSelSecond,
  output logic [PINS-1:0]       pinFirst,
  output logic [PINS-1:0]       pinSecond,
  output logic                  fifoFull,
  output logic                  fifoEmpty,
  output logic                  fifoWof,
  output logic                  phaseErr
);
  ctl_strobe_t       ctlStrobes;
  logic [WORD_W-1:0] headWord;

  wsh_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) uFifo (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .pop(ctlStrobes.load), .wofClear(wofClear), .rdData(headWord),
    .full(fifoFull), .empty(fifoEmpty), .wof(fifoWof)
  );

  wsh_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .enable(enable), .clkDiv(clkDiv),
    .clkPhase(clkPhase), .shiftCount(shiftCount), .fifoEmpty(fifoEmpty),
    .strobes(ctlStrobes), .phaseErr(phaseErr)
  );

  wsh_datapath #(.PINS(PINS)) uData (
    .clk(clk), .rstN(rstN), .strobes(ctlStrobes), .loadWord(headWord),
    .shiftAmt(shiftAmt), .pinClkMode(pinClkMode), .pinInvert(pinInvert),
    .pinSelFirst(pinSelFirst), .pinSelSecond(pinSelSecond),
    .pinFirst(pinFirst), .pinSecond(pinSecond)
  );
endmodule

// File: rtl/wsh_checker.sv
module wsh_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic wrValid,
  input logic wofClear,
  input logic fifoFull,
  input logic fifoEmpty,
  input logic fifoWof,
  input logic loadStrobe
);
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(fifoFull && fifoEmpty));

  p_full_kept_r8: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && !loadStrobe) |=> fifoFull);

  p_wof_set_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoFull && wrValid) |=> fifoWof);

  p_wof_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoWof && !wofClear) |=> fifoWof);

  p_wof_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wofClear && !(fifoFull && wrValid)) |=> !fifoWof);

  p_no_drain_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !loadStrobe);

  p_empty_no_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    fifoEmpty |-> !loadStrobe);
endmodule

bind ddr_word_shifter wsh_checker uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .wrValid(wrValid),
  .wofClear(wofClear), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .fifoWof(fifoWof), .loadStrobe(ctlStrobes.load)
);

// File: tb/sim_ddr_word_shifter.sv
`timescale 1ns/1ps
module sim_ddr_word_shifter;
  localparam int DEPTH = 4;
  localparam int NP    = 8;

  logic        clk = 1'b0;
  logic        rstN, enable, wrValid, wofClear;
  logic [31:0] wrData;
  logic [4:0]  shiftAmt, shiftCount, clkPhase;
  logic [3:0]  clkDiv;
  logic [7:0]  pinClkMode, pinInvert, pinFirst, pinSecond;
  logic [39:0] pinSelFirst, pinSelSecond;
  logic        fifoFull, fifoEmpty, fifoWof, phaseErr;

  int compared = 0;
  int mismatched = 0;

  logic [31:0] q[$];
  logic [31:0] mSr;
  int          mLeft, mDivCnt;
  bit          mWof;

  always #2.5 clk = ~clk;

  ddr_word_shifter u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .wrValid(wrValid), .wrData(wrData),
    .wofClear(wofClear), .shiftAmt(shiftAmt), .shiftCount(shiftCount),
    .clkDiv(clkDiv), .clkPhase(clkPhase), .pinClkMode(pinClkMode),
    .pinInvert(pinInvert), .pinSelFirst(pinSelFirst), .pinSelSecond(pinSelSecond),
    .pinFirst(pinFirst), .pinSecond(pinSecond), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .fifoWof(fifoWof), .phaseErr(phaseErr)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int divOf();
    return (clkDiv == 0) ? 1 : int'(clkDiv);
  endfunction

  // R6/R7: clock level of a half-cycle slot
  function automatic bit slotHigh(int k);
    int d, ph;
    d  = divOf();
    ph = (int'(clkPhase) >= 2 * d) ? 0 : int'(clkPhase);
    return ((k - ph + 2 * d) % (2 * d)) < d;
  endfunction

  task automatic compareAll();
    logic [7:0] eF, eS;
    for (int p = 0; p < NP; p++) begin
      bit a, b;
      if (pinClkMode[p]) begin
        a = slotHigh(2 * mDivCnt);
        b = slotHigh(2 * mDivCnt + 1);
      end else begin
        a = mSr[pinSelFirst[p*5 +: 5]];
        b = mSr[pinSelSecond[p*5 +: 5]];
      end
      eF[p] = a ^ pinInvert[p];
      eS[p] = b ^ pinInvert[p];
    end
    check("R2 R3 R5 R6", "pinFirst", 32'(pinFirst), 32'(eF));
    check("R2 R3 R5 R6", "pinSecond", 32'(pinSecond), 32'(eS));
    check("R8", "fifoFull", 32'(fifoFull), 32'(q.size() == DEPTH));
    check("R8", "fifoEmpty", 32'(fifoEmpty), 32'(q.size() == 0));
    check("R9", "fifoWof", 32'(fifoWof), 32'(mWof));
    check("R7", "phaseErr", 32'(phaseErr), 32'(int'(clkPhase) >= 2 * divOf()));
  endtask

  task automatic modelEdge();
    bit wasFull, tick;
    int d;
    d = divOf();
    wasFull = (q.size() == DEPTH);
    tick = enable && (mDivCnt >= d - 1);
    if (tick) begin
      if (mLeft == 0 && q.size() > 0) begin
        mSr = q.pop_front();
        mLeft = int'(shiftCount);
      end else begin
        mSr = (mSr >> shiftAmt) | (mSr << (32 - int'(shiftAmt)));
        if (mLeft > 0) mLeft--;
      end
    end
    if (wrValid) begin
      if (wasFull) mWof = 1'b1;
      else q.push_back(wrData);
    end else if (wofClear) mWof = 1'b0;
    if (wrValid && wasFull) mWof = 1'b1;
    else if (wofClear && !(wrValid && wasFull)) mWof = 1'b0;
    if (!enable || tick) mDivCnt = 0;
    else mDivCnt++;
  endtask

  // inputs are set after a falling edge; compare, take the rising edge, update model
  task automatic cyc();
    #1;
    compareAll();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic push(logic [31:0] w);
    wrValid = 1'b1;
    wrData  = w;
    cyc();
    wrValid = 1'b0;
  endtask

  task automatic pause();
    enable = 1'b0;
    cyc();
  endtask

  initial begin
    #(200000 * 5);
    mismatched++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; enable = 1'b0; wrValid = 1'b0; wofClear = 1'b0; wrData = '0;
    shiftAmt = 5'd1; shiftCount = 5'd3; clkDiv = 4'd1; clkPhase = 5'd0;
    pinClkMode = 8'b0100_0011;
    pinInvert  = 8'b1000_1010;
    pinSelFirst = '0; pinSelSecond = '0;
    pinSelFirst[2*5 +: 5] = 5'd0;  pinSelSecond[2*5 +: 5] = 5'd1;
    pinSelFirst[3*5 +: 5] = 5'd31; pinSelSecond[3*5 +: 5] = 5'd16;
    pinSelFirst[4*5 +: 5] = 5'd5;  pinSelSecond[4*5 +: 5] = 5'd5;
    pinSelFirst[5*5 +: 5] = 5'd7;  pinSelSecond[5*5 +: 5] = 5'd8;
    pinSelFirst[7*5 +: 5] = 5'd30; pinSelSecond[7*5 +: 5] = 5'd2;
    mSr = '0; mLeft = 0; mDivCnt = 0; mWof = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // reset state: empty queue, zero word, no overflow (R8, R9)
    run(2);

    // R1, R8: fill while disabled; the fifth write is dropped and flags R9
    for (int i = 0; i < 5; i++) push(32'h9E37_79B9 * (i + 1));
    run(3);
    // R9: set wins over a same-cycle clear, then a plain clear
    wrValid = 1'b1; wofClear = 1'b1; wrData = 32'hDEAD_BEEF; cyc();
    wrValid = 1'b0; cyc();
    cyc();
    wofClear = 1'b0; run(2);

    // R2, R3, R5, R6: divide by one, four steps per word, drains the queue
    enable = 1'b1;
    run(20);
    // R4: empty at reload keeps rotating, then a late word loads
    run(6);
    push(32'hF00D_1234);
    run(8);

    // R2, R6: divide by three, phase two, rotate by eight, two steps per word
    pause();
    clkDiv = 4'd3; clkPhase = 5'd2; shiftAmt = 5'd8; shiftCount = 5'd1;
    push(32'h0123_4567); push(32'h89AB_CDEF); push(32'hC3A5_5A3C);
    enable = 1'b1;
    run(30);

    // R7: phase out of range is flagged and acts as zero
    pause();
    clkDiv = 4'd2; clkPhase = 5'd5; shiftAmt = 5'd3;
    push(32'h8000_0001);
    enable = 1'b1;
    run(12);
    // R2: divider value zero acts as one, phase one
    pause();
    clkDiv = 4'd0; clkPhase = 5'd1;
    enable = 1'b1;
    run(6);

    // R3: no rotation and zero count: a new word on every step while writing
    pause();
    clkDiv = 4'd1; clkPhase = 5'd1; shiftAmt = 5'd0; shiftCount = 5'd0;
    enable = 1'b1;
    for (int i = 0; i < 10; i++) push(32'h1357_9BDF ^ (32'h1111_1111 * i));
    run(4);

    // R8: queue full while enabled, with a write racing a load
    pause();
    shiftCount = 5'd2; shiftAmt = 5'd31; clkDiv = 4'd2;
    for (int i = 0; i < 4; i++) push(32'hA5A5_0000 + i);
    enable = 1'b1;
    for (int i = 0; i < 6; i++) push(32'h5A5A_0000 + i);
    run(20);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule